// File: doc/BRIEF.md
# Embedded Sync Word Decoder for 4:2:2 Component Video

This block sits on a parallel 4:2:2 component video stream that carries one word per clock, 8 or 10 bits wide, with its line and field timing carried inside the data stream rather than on separate sync pins. It watches for the reserved preamble of all-ones followed by two all-zero words. It then reads the word that follows as a timing word, checks the word's protection bits and, if the word is sound, updates the field, vertical blanking and horizontal blanking state from it.

A timing word with its horizontal flag clear opens a run of active video. The block splits that run into luma and chroma. The incoming order is blue-difference, luma, red-difference, luma. The block presents each luma sample together with the chroma pair that the two luma samples of a group share. A start-of-frame pulse marks the first active line of a new frame. A one-cycle error pulse flags any timing word whose protection bits are inconsistent. Because timing is rebuilt entirely from the received words, the block keeps no pixel or line counters.

Top module: `vid656_dec`

## Requirements
- R1: While reset is asserted and directly after it, pix_valid, sof and code_err are 0, field is 0, and vblank and hblank are 1.
- R2: A timing word is taken only from the fourth word of the sequence all-ones, all-zero, all-zero, matched on the top 8 bits of the word. The same value arriving without that preamble changes no flag and raises no error.
- R3: A timing word is laid out MSB to LSB as 1, F, V, H, then four protection bits. When the word is sound, field takes F, vblank takes V and hblank takes H, visible in the cycle after that word.
- R4: Protection bits, from bit 3 down to bit 0, must equal V^H, F^H, F^V and F^V^H, and bit 7 must be 1. Otherwise code_err is 1 for exactly the cycle after the word, and field, vblank and hblank keep their values.
- R5: After a sound timing word with H=0, the next words are taken as Cb, Y0, Cr, Y1, repeating. In the cycle after the Cr word, pix_valid=1 with y=Y0 and that group's Cb and Cr. In the cycle after the Y1 word, pix_valid=1 with y=Y1 and the same Cb and Cr.
- R6: A sound timing word with H=1 ends active video. No pix_valid follows until the next sound timing word with H=0.
- R7: sof is a one-cycle pulse in the cycle after a sound timing word with F=0, V=0, H=0. It is issued only if a sound timing word with V=1 and F=0 has arrived since the previous sof or since reset. Later active-line starts give no sof until that condition holds again.
- R8: With WORD_W=10, the two LSBs of preamble and timing words are ignored when matching and decoding, while video samples are passed through at the full 10 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | WORD_W | Incoming video word |
| pix_valid | output | 1 | One luma sample with its chroma pair is presented |
| y | output | WORD_W | Luma sample |
| cb | output | WORD_W | Blue-difference sample shared by the pair |
| cr | output | WORD_W | Red-difference sample shared by the pair |
| field | output | 1 | Field flag from the last sound timing word |
| vblank | output | 1 | Vertical blanking flag |
| hblank | output | 1 | Horizontal blanking flag |
| sof | output | 1 | Start-of-frame pulse |
| code_err | output | 1 | Protection-bit error pulse |

## Verification
The assertions assume that the stream obeys the word grammar. Video words inside an active run never use the reserved all-ones or all-zero values. Every active run is made of whole Cb, Y, Cr, Y groups and ends with its own preamble. Two timing words are always at least four words apart. The stimulus honours these rules. It places preambles only on group boundaries and uses only video values away from the reserved codes. The one exception is a deliberate bare timing value without a preamble, which is sent while active video is already closed.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_ONES,
        ST_ZERO1,
        ST_ZERO2
    } sync_state_t;

    localparam logic [7:0] TAG_ONES = 8'hFF;
    localparam logic [7:0] TAG_ZERO = 8'h00;

    function automatic logic tag_sound(input logic [7:0] t);
        logic f, v, h;
        f = t[6];
        v = t[5];
        h = t[4];
        return t[7] && (t[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
    endfunction

endpackage

// File: rtl/vid656_sync_fsm.sv
module vid656_sync_fsm
    import vid656_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tag,
    output logic       at_code,
    output logic       hunting
);

    sync_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_HUNT;
        unique case (state)
            ST_HUNT:  state_nx = (tag == TAG_ONES) ? ST_ONES : ST_HUNT;
            ST_ONES:  state_nx = (tag == TAG_ZERO) ? ST_ZERO1 :
                                 (tag == TAG_ONES) ? ST_ONES : ST_HUNT;
            ST_ZERO1: state_nx = (tag == TAG_ZERO) ? ST_ZERO2 :
                                 (tag == TAG_ONES) ? ST_ONES : ST_HUNT;
            ST_ZERO2: state_nx = ST_HUNT;
        endcase
    end

    always_comb begin
        at_code = (state == ST_ZERO2);
        hunting = (state == ST_HUNT);
    end

endmodule

// File: rtl/vid656_tag_check.sv
module vid656_tag_check
    import vid656_pkg::*;
(
    input  logic [7:0] tag,
    output logic       sound,
    output logic       f_bit,
    output logic       v_bit,
    output logic       h_bit
);

    always_comb begin
        sound = tag_sound(tag);
        f_bit = tag[6];
        v_bit = tag[5];
        h_bit = tag[4];
    end

endmodule

// File: rtl/vid656_demux.sv
module vid656_demux #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              take,
    input  logic [WORD_W-1:0] din,
    output logic              pix_valid,
    output logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] cb,
    output logic [WORD_W-1:0] cr
);

    logic              active;
    logic [1:0]        phase;
    logic [WORD_W-1:0] cb_q, y0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            phase     <= '0;
            cb_q      <= '0;
            y0_q      <= '0;
            pix_valid <= 1'b0;
            y         <= '0;
            cb        <= '0;
            cr        <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (start) begin
                active <= 1'b1;
                phase  <= '0;
            end else if (stop) begin
                active <= 1'b0;
            end else if (take && active) begin
                phase <= phase + 2'd1;
                unique case (phase)
                    2'd0: cb_q <= din;
                    2'd1: y0_q <= din;
                    2'd2: begin
                        y         <= y0_q;
                        cb        <= cb_q;
                        cr        <= din;
                        pix_valid <= 1'b1;
                    end
                    2'd3: begin
                        y         <= din;
                        pix_valid <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vid656_dec.sv
module vid656_dec
    import vid656_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    output logic              pix_valid,
    output logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] cb,
    output logic [WORD_W-1:0] cr,
    output logic              field,
    output logic              vblank,
    output logic              hblank,
    output logic              sof,
    output logic              code_err
);

    localparam int TAG_LSB = WORD_W - 8;

    logic [7:0] tag;
    logic       at_code, hunting;
    logic       sound, f_bit, v_bit, h_bit;
    logic       armed;
    logic       good_code, start, stop, take;

    // Matching uses only the top 8 bits; extra LSBs of wide words drop out.
    assign tag = din[WORD_W-1:TAG_LSB];

    vid656_sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag     (tag),
        .at_code (at_code),
        .hunting (hunting)
    );

    vid656_tag_check u_chk_tag (
        .tag   (tag),
        .sound (sound),
        .f_bit (f_bit),
        .v_bit (v_bit),
        .h_bit (h_bit)
    );

    assign good_code = at_code && sound;
    assign start     = good_code && !h_bit;
    assign stop      = good_code &&  h_bit;
    assign take      = hunting && (tag != TAG_ONES);

    vid656_demux #(.WORD_W(WORD_W)) u_demux (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .take      (take),
        .din       (din),
        .pix_valid (pix_valid),
        .y         (y),
        .cb        (cb),
        .cr        (cr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field    <= 1'b0;
            vblank   <= 1'b1;
            hblank   <= 1'b1;
            sof      <= 1'b0;
            code_err <= 1'b0;
            armed    <= 1'b0;
        end else begin
            sof      <= 1'b0;
            code_err <= at_code && !sound;
            if (good_code) begin
                field  <= f_bit;
                vblank <= v_bit;
                hblank <= h_bit;
                if (v_bit && !f_bit) begin
                    armed <= 1'b1;
                end else if (armed && !f_bit && !h_bit) begin
                    sof   <= 1'b1;
                    armed <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/vid656_chk.sv
module vid656_chk (
    input logic clk,
    input logic rst_n,
    input logic pix_valid,
    input logic field,
    input logic vblank,
    input logic hblank,
    input logic sof,
    input logic code_err
);

    a_r4_err_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> ($stable(field) && $stable(vblank) && $stable(hblank)));

    a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> !code_err);

    a_r6_pix_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !hblank);

    a_r5_pix_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |=> pix_valid);

    a_r7_sof_state: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (!vblank && !hblank && !field));

    a_r7_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

endmodule

bind vid656_dec vid656_chk u_vid656_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .field     (field),
    .vblank    (vblank),
    .hblank    (hblank),
    .sof       (sof),
    .code_err  (code_err)
);

// File: tb/sim_vid656_dec.sv
module sim_vid656_dec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din8 = '0;
    logic [9:0]  din10 = '0;

    logic        pv8, f8, vb8, hb8, sof8, err8;
    logic [7:0]  y8, cb8, cr8;
    logic        pv10, f10, vb10, hb10, sof10, err10;
    logic [9:0]  y10, cb10, cr10;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vid656_dec #(.WORD_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din8),
        .pix_valid(pv8), .y(y8), .cb(cb8), .cr(cr8),
        .field(f8), .vblank(vb8), .hblank(hb8), .sof(sof8), .code_err(err8)
    );

    vid656_dec #(.WORD_W(10)) u1 (
        .clk(clk), .rst_n(rst_n), .din(din10),
        .pix_valid(pv10), .y(y10), .cb(cb10), .cr(cr10),
        .field(f10), .vblank(vb10), .hblank(hb10), .sof(sof10), .code_err(err10)
    );

    // Entry: {word, pix_valid, y, cb, cr, field, vblank, hblank, sof, code_err}
    // Expected outputs are those seen in the cycle after the word is taken.
    localparam int NVEC = 59;
    localparam logic [37:0] VEC [NVEC] = '{
        {8'h10, 1'b0, 24'h000000, 5'b01100},
        {8'hFF, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'hB6, 1'b0, 24'h000000, 5'b01100},
        {8'hFF, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'hAB, 1'b0, 24'h000000, 5'b01000},
        {8'h40, 1'b0, 24'h000000, 5'b01000},
        {8'h50, 1'b0, 24'h000000, 5'b01000},
        {8'h60, 1'b1, 24'h504060, 5'b01000},
        {8'h70, 1'b1, 24'h704060, 5'b01000},
        {8'hFF, 1'b0, 24'h000000, 5'b01000},
        {8'h00, 1'b0, 24'h000000, 5'b01000},
        {8'h00, 1'b0, 24'h000000, 5'b01000},
        {8'hB6, 1'b0, 24'h000000, 5'b01100},
        {8'hFF, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'h00, 1'b0, 24'h000000, 5'b01100},
        {8'h80, 1'b0, 24'h000000, 5'b00010},
        {8'h11, 1'b0, 24'h000000, 5'b00000},
        {8'h22, 1'b0, 24'h000000, 5'b00000},
        {8'h33, 1'b1, 24'h221133, 5'b00000},
        {8'h44, 1'b1, 24'h441133, 5'b00000},
        {8'h55, 1'b0, 24'h000000, 5'b00000},
        {8'h66, 1'b0, 24'h000000, 5'b00000},
        {8'h77, 1'b1, 24'h665577, 5'b00000},
        {8'h88, 1'b1, 24'h885577, 5'b00000},
        {8'hFF, 1'b0, 24'h000000, 5'b00000},
        {8'h00, 1'b0, 24'h000000, 5'b00000},
        {8'h00, 1'b0, 24'h000000, 5'b00000},
        {8'h9D, 1'b0, 24'h000000, 5'b00100},
        {8'h99, 1'b0, 24'h000000, 5'b00100},
        {8'hFF, 1'b0, 24'h000000, 5'b00100},
        {8'h00, 1'b0, 24'h000000, 5'b00100},
        {8'h00, 1'b0, 24'h000000, 5'b00100},
        {8'h80, 1'b0, 24'h000000, 5'b00000},
        {8'h12, 1'b0, 24'h000000, 5'b00000},
        {8'h34, 1'b0, 24'h000000, 5'b00000},
        {8'h56, 1'b1, 24'h341256, 5'b00000},
        {8'h78, 1'b1, 24'h781256, 5'b00000},
        {8'hFF, 1'b0, 24'h000000, 5'b00000},
        {8'h00, 1'b0, 24'h000000, 5'b00000},
        {8'h00, 1'b0, 24'h000000, 5'b00000},
        {8'hDA, 1'b0, 24'h000000, 5'b10100},
        {8'hFF, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h81, 1'b0, 24'h000000, 5'b10101},
        {8'h20, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h80, 1'b0, 24'h000000, 5'b10100},
        {8'hFF, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h00, 1'b0, 24'h000000, 5'b10100},
        {8'h1D, 1'b0, 24'h000000, 5'b10101},
        {8'h30, 1'b0, 24'h000000, 5'b10100}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        if (i == 20 || i == 37)      return "R7";
        if (i == 49 || i == 57)      return "R4";
        if (i >= 51 && i <= 53)      return "R2";
        if (i == 33)                 return "R6";
        if ((i >= 9 && i <= 12) || (i >= 21 && i <= 28) || (i >= 38 && i <= 41)) return "R5";
        return "R3";
    endfunction

    task automatic send10(input logic [9:0] w);
        @(negedge clk);
        din10 = w;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held in reset
        check("R1", "pix_valid", pv8, 0);
        check("R1", "field", f8, 0);
        check("R1", "vblank", vb8, 1);
        check("R1", "hblank", hb8, 1);
        check("R1", "sof", sof8, 0);
        check("R1", "code_err", err8, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [37:0] e;
            string r;
            e = VEC[i];
            r = req_of(i);
            @(negedge clk);
            din8 = e[37:30];
            @(posedge clk);
            #1;
            check(r, "pix_valid", pv8, e[29]);
            if (e[29]) begin
                check(r, "y", y8, e[28:21]);
                check(r, "cb", cb8, e[20:13]);
                check(r, "cr", cr8, e[12:5]);
            end
            check(r, "field", f8, e[4]);
            check(r, "vblank", vb8, e[3]);
            check(r, "hblank", hb8, e[2]);
            check(r, "sof", sof8, e[1]);
            check(r, "code_err", err8, e[0]);
        end

        // R8: wide words, LSBs of preamble and timing word are not zero
        send10(10'h3FF);
        send10(10'h002);
        send10(10'h001);
        send10(10'h203);
        check("R8", "vblank", vb10, 0);
        check("R8", "hblank", hb10, 0);
        check("R8", "code_err", err10, 0);
        send10(10'h155);
        send10(10'h1AA);
        check("R8", "pix_valid", pv10, 0);
        send10(10'h2CC);
        check("R8", "pix_valid", pv10, 1);
        check("R8", "y", y10, 10'h1AA);
        check("R8", "cb", cb10, 10'h155);
        check("R8", "cr", cr10, 10'h2CC);
        send10(10'h0F3);
        check("R8", "pix_valid", pv10, 1);
        check("R8", "y", y10, 10'h0F3);
        send10(10'h3FE);
        send10(10'h003);
        send10(10'h000);
        send10(10'h206);
        check("R8", "code_err", err10, 1);
        check("R8", "hblank", hb10, 0);

        // R1: reset again in mid-stream restores the idle flags
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "field", f8, 0);
        check("R1", "vblank", vb8, 1);
        check("R1", "hblank", hb8, 1);
        check("R1", "pix_valid", pv10, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule